// File: doc/BRIEF.md
# Raster-Synchronized Bus Slot Arbiter

This block decides, once per bus cycle, which single requester gets the shared memory bus. The requesters are four fixed-slot DMA channels, a bitplane fetcher, a coprocessor, a block-transfer engine (blitter) and a CPU. Cycles come in two kinds, chosen by the low bit of a slot index that the raster timing logic supplies. Odd cycles belong to DMA alone. Even cycles are shared, and the CPU is always the lowest claimant on them. The bitplane depth and the resolution mode decide whether bitplane fetches also take some even cycles.

The block also holds a 16-bit DMA control word. Software never writes this word directly. Bit 15 of each write chooses between setting and clearing the bits that are 1 in the data. The control word holds an enable for each channel, a master enable and a blitter-priority bit. When blitter priority is set, the CPU is shut out of even cycles while the blitter asks for the bus. When it is clear, the CPU is guaranteed a turn.

A decision is made from the inputs sampled at a rising edge. The one-hot grant, the idle flag and the CPU wait flag are registered, so they are visible for the whole next cycle.

Top module: `bus_slot_arbiter`

## Requirements
- R1: A cycle whose `slot_idx[0]` is 1 (odd) is never granted to the CPU. Only DMA requesters can win it.
- R2: `grant` is one-hot or all zero. `idle` is 1 exactly when `grant` is all zero. The grant bits are: bits 0 to 3 are fixed channels 0 to 3, bit 4 is the bitplane fetcher, bit 5 is the coprocessor, bit 6 is the blitter and bit 7 is the CPU.
- R3: A control write with `ctl_wdata[15]`=1 sets every control bit that is 1 in `ctl_wdata[14:0]`. A write with `ctl_wdata[15]`=0 clears every such bit. All other bits keep their value, and bit 15 always reads back as 0.
- R4: A DMA requester with grant bit k (k = 0 to 6) is eligible only when control bit k and the master bit 9 are both 1. The CPU needs no enable.
- R5: On odd cycles the priority order is: bitplane, then fixed channels 0 to 3 (lowest index first), then coprocessor, then blitter. Fixed channels are never granted an even cycle.
- R6: In low resolution (`hires`=0) with `bpl_depth` of 4 or less, the bitplane fetcher never gets an even cycle. With a depth of 5 or more, it may take the even slots whose `slot_idx[1:0]` is 2'b10 (two in each 8-cycle group).
- R7: In high resolution with a depth of 2 or less, bitplane fetches use only odd cycles. With a depth of 3, they use the even slots whose `slot_idx[1:0]` is 2'b10. With a depth of 4 or more, they may take every even slot.
- R8: On an even cycle the priority order is: bitplane (in its allowed slot), then coprocessor, then blitter, then CPU.
- R9: When control bit 10 (blitter priority) is 1, the CPU never wins an even cycle in which the eligible blitter requests.
- R10: A modulo-4 counter advances on every even cycle in which the eligible blitter requests. When bit 10 is 0 and the counter value is 3 on such a cycle, a requesting CPU beats the blitter on that cycle.
- R11: `cpu_wait` is 1 when the CPU requested in the sampled cycle and was not granted. Outputs follow the sampled inputs by one clock. After reset, `grant` is 0, `idle` is 1, `cpu_wait` is 0 and the control word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| slot_idx | input | 3 | Position of the cycle in the 8-cycle group; bit 0 = 1 means odd |
| hires | input | 1 | High-resolution display mode |
| bpl_depth | input | 3 | Number of active bitplanes |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control write data; bit 15 selects set (1) or clear (0) |
| req_fix | input | 4 | Requests of the fixed-slot DMA channels |
| req_bpl | input | 1 | Bitplane fetch request |
| req_cop | input | 1 | Coprocessor request |
| req_blt | input | 1 | Blitter request |
| req_cpu | input | 1 | CPU request |
| grant | output | 8 | Registered one-hot grant |
| idle | output | 1 | Registered flag: no grant this cycle |
| cpu_wait | output | 1 | Registered flag: the CPU asked and was refused |
| dma_ctrl | output | 16 | Current control word |

## Verification
The bench goes after the boundary depths in each resolution: lores depths 4 and 5, and hires depths 2, 3 and 4. A wrong threshold would let bitplane fetches steal even cycles that belong to the CPU, or would starve the fetcher. It checks odd cycles while only the CPU requests. A design that ignored parity there would hand the CPU a slot it cannot use. It runs long blitter bursts with the priority bit set and cleared. A broken share counter would show up as a CPU that never runs, or one that runs on the wrong even cycle. Set and clear writes that touch the master bit show whether the writes really leave the other bits alone, and whether clearing the master bit silences every channel.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam int N_FIX    = 4;
  localparam int N_REQ    = N_FIX + 4;
  localparam int G_BPL    = N_FIX;
  localparam int G_COP    = N_FIX + 1;
  localparam int G_BLT    = N_FIX + 2;
  localparam int G_CPU    = N_FIX + 3;
  localparam int CTL_W    = 16;
  localparam int B_MASTER = 9;
  localparam int B_BLTPRI = 10;
  localparam int SLOT_W   = 3;
  localparam int DEPTH_W  = 3;
  localparam int SHARE    = 4;

  typedef enum logic [1:0] {
    FETCH_ODD_ONLY,
    FETCH_TWO_PER_GROUP,
    FETCH_ALL_EVEN
  } fetch_mode_e;
endpackage

// File: rtl/bsa_ctrl_reg.sv
module bsa_ctrl_reg #(
  parameter int W = bsa_pkg::CTL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q
);
  logic [W-1:0] mask;
  assign mask = {1'b0, wdata[W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we) begin
      if (wdata[W-1]) ctrl_q <= ctrl_q | mask;
      else            ctrl_q <= ctrl_q & ~mask;
    end
  end
endmodule

// File: rtl/bsa_fetch_map.sv
module bsa_fetch_map
  import bsa_pkg::*;
#(
  parameter int SW = SLOT_W,
  parameter int DW = DEPTH_W
) (
  input  logic          hires,
  input  logic [DW-1:0] depth,
  input  logic [SW-1:0] slot_idx,
  output logic          steal_even
);
  fetch_mode_e mode;

  always_comb begin
    if (hires) begin
      if (depth <= DW'(2))      mode = FETCH_ODD_ONLY;
      else if (depth == DW'(3)) mode = FETCH_TWO_PER_GROUP;
      else                      mode = FETCH_ALL_EVEN;
    end else begin
      if (depth <= DW'(4))      mode = FETCH_ODD_ONLY;
      else                      mode = FETCH_TWO_PER_GROUP;
    end
  end

  always_comb begin
    steal_even = 1'b0;
    if (!slot_idx[0]) begin
      case (mode)
        FETCH_ALL_EVEN:      steal_even = 1'b1;
        FETCH_TWO_PER_GROUP: steal_even = slot_idx[1];
        default:             steal_even = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bsa_cpu_share.sv
module bsa_cpu_share #(
  parameter int SHARE = bsa_pkg::SHARE
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic cpu_turn
);
  localparam int CW = (SHARE > 1) ? $clog2(SHARE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SHARE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign cpu_turn = (cnt == LAST);
endmodule

// File: rtl/bsa_pick.sv
module bsa_pick
  import bsa_pkg::*;
#(
  parameter int NF = N_FIX,
  parameter int NR = N_REQ
) (
  input  logic          odd,
  input  logic [NR-1:0] elig,
  input  logic          steal,
  input  logic          blt_pri,
  input  logic          cpu_turn,
  output logic [NR-1:0] pick
);
  localparam int I_BPL = NF;
  localparam int I_COP = NF + 1;
  localparam int I_BLT = NF + 2;
  localparam int I_CPU = NF + 3;

  logic taken;
  logic cpu_claims;

  assign cpu_claims = cpu_turn && !blt_pri && elig[I_CPU];

  always_comb begin
    pick  = '0;
    taken = 1'b0;
    if (odd) begin
      if (elig[I_BPL]) begin
        pick[I_BPL] = 1'b1;
        taken = 1'b1;
      end
      for (int k = 0; k < NF; k++) begin
        if (!taken && elig[k]) begin
          pick[k] = 1'b1;
          taken = 1'b1;
        end
      end
      if (!taken && elig[I_COP]) begin
        pick[I_COP] = 1'b1;
        taken = 1'b1;
      end
      if (!taken && elig[I_BLT]) begin
        pick[I_BLT] = 1'b1;
        taken = 1'b1;
      end
    end else begin
      if (steal && elig[I_BPL])            pick[I_BPL] = 1'b1;
      else if (elig[I_COP])                pick[I_COP] = 1'b1;
      else if (elig[I_BLT] && !cpu_claims) pick[I_BLT] = 1'b1;
      else if (elig[I_CPU])                pick[I_CPU] = 1'b1;
    end
  end
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
  import bsa_pkg::*;
#(
  parameter int NF = N_FIX,
  parameter int SW = SLOT_W,
  parameter int DW = DEPTH_W,
  parameter int CW = CTL_W,
  parameter int SH = SHARE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SW-1:0]  slot_idx,
  input  logic           hires,
  input  logic [DW-1:0]  bpl_depth,
  input  logic           ctl_we,
  input  logic [CW-1:0]  ctl_wdata,
  input  logic [NF-1:0]  req_fix,
  input  logic           req_bpl,
  input  logic           req_cop,
  input  logic           req_blt,
  input  logic           req_cpu,
  output logic [NF+3:0]  grant,
  output logic           idle,
  output logic           cpu_wait,
  output logic [CW-1:0]  dma_ctrl
);
  localparam int NR    = NF + 4;
  localparam int I_BLT = NF + 2;
  localparam int I_CPU = NF + 3;

  logic [NR-1:0] req_vec;
  logic [NR-1:0] elig;
  logic [NR-1:0] pick;
  logic          steal;
  logic          cpu_turn;
  logic          share_tick;

  assign req_vec = {req_cpu, req_blt, req_cop, req_bpl, req_fix};

  bsa_ctrl_reg #(.W(CW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .ctrl_q(dma_ctrl)
  );

  genvar g;
  generate
    for (g = 0; g < NR - 1; g++) begin : g_elig
      assign elig[g] = req_vec[g] && dma_ctrl[g] && dma_ctrl[B_MASTER];
    end
  endgenerate
  assign elig[I_CPU] = req_vec[I_CPU];

  bsa_fetch_map #(.SW(SW), .DW(DW)) u_map (
    .hires     (hires),
    .depth     (bpl_depth),
    .slot_idx  (slot_idx),
    .steal_even(steal)
  );

  assign share_tick = !slot_idx[0] && elig[I_BLT];

  bsa_cpu_share #(.SHARE(SH)) u_share (
    .clk     (clk),
    .rst     (rst),
    .tick    (share_tick),
    .cpu_turn(cpu_turn)
  );

  bsa_pick #(.NF(NF), .NR(NR)) u_pick (
    .odd     (slot_idx[0]),
    .elig    (elig),
    .steal   (steal),
    .blt_pri (dma_ctrl[B_BLTPRI]),
    .cpu_turn(cpu_turn),
    .pick    (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant    <= '0;
      idle     <= 1'b1;
      cpu_wait <= 1'b0;
    end else begin
      grant    <= pick;
      idle     <= (pick == '0);
      cpu_wait <= req_cpu && !pick[I_CPU];
    end
  end
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker
  import bsa_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              hires,
  input logic [DEPTH_W-1:0] bpl_depth,
  input logic              ctl_we,
  input logic [CTL_W-1:0]  ctl_wdata,
  input logic              req_blt,
  input logic              req_cpu,
  input logic [N_REQ-1:0]  grant,
  input logic              idle,
  input logic              cpu_wait,
  input logic [CTL_W-1:0]  dma_ctrl
);
  logic [N_REQ-2:0] en_mask;
  assign en_mask = dma_ctrl[B_MASTER] ? dma_ctrl[N_REQ-2:0] : '0;

  assert_odd_no_cpu_R1: assert property (@(posedge clk) disable iff (rst)
    $past(slot_idx[0]) |-> !grant[G_CPU]);

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (idle == (grant == '0)));

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[15]) |=>
      ((dma_ctrl[14:0] & $past(ctl_wdata[14:0])) == $past(ctl_wdata[14:0])));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_wdata[15]) |=>
      ((dma_ctrl[14:0] & $past(ctl_wdata[14:0])) == 15'd0));

  assert_top_bit_R3: assert property (@(posedge clk) disable iff (rst)
    !dma_ctrl[15]);

  assert_enable_R4: assert property (@(posedge clk) disable iff (rst)
    (grant[N_REQ-2:0] & ~$past(en_mask)) == '0);

  assert_fix_odd_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!slot_idx[0]) |-> (grant[N_FIX-1:0] == '0));

  assert_lores_shallow_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!slot_idx[0] && !hires && (bpl_depth <= 3'd4)) |-> !grant[G_BPL]);

  assert_hires_shallow_R7: assert property (@(posedge clk) disable iff (rst)
    $past(!slot_idx[0] && hires && (bpl_depth <= 3'd2)) |-> !grant[G_BPL]);

  assert_blt_pri_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!slot_idx[0] && dma_ctrl[B_BLTPRI] && dma_ctrl[B_MASTER] &&
          dma_ctrl[G_BLT] && req_blt) |-> !grant[G_CPU]);

  assert_wait_R11: assert property (@(posedge clk) disable iff (rst)
    cpu_wait |-> ($past(req_cpu) && !grant[G_CPU]));
endmodule

bind bus_slot_arbiter bsa_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .slot_idx (slot_idx),
  .hires    (hires),
  .bpl_depth(bpl_depth),
  .ctl_we   (ctl_we),
  .ctl_wdata(ctl_wdata),
  .req_blt  (req_blt),
  .req_cpu  (req_cpu),
  .grant    (grant),
  .idle     (idle),
  .cpu_wait (cpu_wait),
  .dma_ctrl (dma_ctrl)
);

// File: tb/sim_bus_slot_arbiter.sv
module sim_bus_slot_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  slot_idx = '0;
  logic        hires = 1'b0;
  logic [2:0]  bpl_depth = '0;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [3:0]  req_fix = '0;
  logic        req_bpl = 1'b0, req_cop = 1'b0, req_blt = 1'b0, req_cpu = 1'b0;
  logic [7:0]  grant;
  logic        idle, cpu_wait;
  logic [15:0] dma_ctrl;

  int errors = 0;
  int checks = 0;
  int slot = 0;
  logic [15:0] m_ctrl = '0;
  int m_cnt = 0;

  always #10 clk = ~clk;

  bus_slot_arbiter u0 (
    .clk(clk), .rst(rst), .slot_idx(slot_idx), .hires(hires),
    .bpl_depth(bpl_depth), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .req_fix(req_fix), .req_bpl(req_bpl), .req_cop(req_cop),
    .req_blt(req_blt), .req_cpu(req_cpu), .grant(grant), .idle(idle),
    .cpu_wait(cpu_wait), .dma_ctrl(dma_ctrl)
  );

  function automatic bit ok_dma(input int k);
    logic [6:0] rv;
    rv = {req_blt, req_cop, req_bpl, req_fix};
    return m_ctrl[9] && m_ctrl[k] && rv[k];
  endfunction

  // behavioural reference: who wins the current cycle (-1 = nobody)
  function automatic int ref_pick();
    bit st;
    if (slot % 2 == 1) begin
      if (ok_dma(4)) return 4;
      for (int k = 0; k < 4; k++) if (ok_dma(k)) return k;
      if (ok_dma(5)) return 5;
      if (ok_dma(6)) return 6;
      return -1;
    end
    st = 0;
    if (hires) begin
      if (bpl_depth == 3) st = (slot % 4 == 2);
      else if (bpl_depth >= 4) st = 1;
    end else if (bpl_depth >= 5) begin
      st = (slot % 4 == 2);
    end
    if (st && ok_dma(4)) return 4;
    if (ok_dma(5)) return 5;
    if (ok_dma(6)) begin
      if (!m_ctrl[10] && m_cnt == 3 && req_cpu) return 7;
      return 6;
    end
    if (req_cpu) return 7;
    return -1;
  endfunction

  task automatic step(input string tag);
    int e;
    bit ew;
    bit tick;
    logic [7:0] eg;
    slot_idx = 3'(slot);
    e   = ref_pick();
    ew  = req_cpu && (e != 7);
    tick = (slot % 2 == 0) && ok_dma(6);
    eg  = (e < 0) ? 8'h00 : 8'(1 << e);
    @(posedge clk);
    if (tick) m_cnt = (m_cnt + 1) % 4;
    if (ctl_we) begin
      if (ctl_wdata[15]) m_ctrl = m_ctrl | {1'b0, ctl_wdata[14:0]};
      else               m_ctrl = m_ctrl & ~{1'b0, ctl_wdata[14:0]};
    end
    @(negedge clk);
    checks++;
    if (grant !== eg || idle !== (eg == 0) || cpu_wait !== ew || dma_ctrl !== m_ctrl) begin
      errors++;
      $display("FAIL %s slot=%0d: grant=%h idle=%b wait=%b ctrl=%h expected grant=%h idle=%b wait=%b ctrl=%h",
               tag, slot, grant, idle, cpu_wait, dma_ctrl, eg, (eg == 0), ew, m_ctrl);
    end
    ctl_we = 1'b0;
    slot = (slot + 1) % 8;
  endtask

  task automatic wr(input logic [15:0] d, input string tag);
    ctl_we = 1'b1;
    ctl_wdata = d;
    step(tag);
  endtask

  task automatic clear_reqs();
    req_fix = '0; req_bpl = 0; req_cop = 0; req_blt = 0; req_cpu = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== 8'h00 || idle !== 1'b1 || cpu_wait !== 1'b0 || dma_ctrl !== 16'h0) begin
      errors++;
      $display("FAIL R11 reset: grant=%h idle=%b wait=%b ctrl=%h expected 00 1 0 0000",
               grant, idle, cpu_wait, dma_ctrl);
    end
    rst = 1'b0;

    // R1 / R11: CPU alone, odd and even slots, nothing enabled
    req_cpu = 1;
    for (int i = 0; i < 8; i++) step("R1");

    // R3: set / clear writes
    wr(16'h827F, "R3");
    wr(16'h8400, "R3");
    wr(16'h0401, "R3");
    wr(16'h0000, "R3");
    wr(16'hFFFF, "R3");
    wr(16'h7B80, "R3");
    wr(16'h827F, "R3");

    // R4: channel 0 disabled, then master off
    clear_reqs();
    req_fix = 4'b0001; req_blt = 1; req_cpu = 1;
    wr(16'h0001, "R4");
    for (int i = 0; i < 4; i++) step("R4");
    wr(16'h0200, "R4");
    for (int i = 0; i < 4; i++) step("R4");
    wr(16'h827F, "R4");

    // R5: odd priority order
    clear_reqs();
    req_fix = 4'b1010; req_cop = 1; req_blt = 1; req_bpl = 1;
    for (int i = 0; i < 4; i++) step("R5");
    req_bpl = 0;
    for (int i = 0; i < 4; i++) step("R5");
    req_fix = 0;
    for (int i = 0; i < 4; i++) step("R5");

    // R6: lores depth boundaries
    clear_reqs();
    req_bpl = 1; req_cpu = 1; hires = 0;
    for (int d = 3; d <= 7; d++) begin
      bpl_depth = 3'(d);
      for (int i = 0; i < 8; i++) step("R6");
    end

    // R7: hires depth boundaries
    hires = 1;
    for (int d = 1; d <= 5; d++) begin
      bpl_depth = 3'(d);
      for (int i = 0; i < 8; i++) step("R7");
    end

    // R8: even priority chain
    clear_reqs();
    hires = 0; bpl_depth = 3'd6;
    req_bpl = 1; req_cop = 1; req_blt = 1; req_cpu = 1;
    for (int i = 0; i < 8; i++) step("R8");
    req_bpl = 0;
    for (int i = 0; i < 8; i++) step("R8");
    req_cop = 0; req_blt = 0;
    for (int i = 0; i < 8; i++) step("R8");

    // R9: blitter priority set
    wr(16'h8400, "R9");
    req_blt = 1; req_cpu = 1;
    for (int i = 0; i < 16; i++) step("R9");

    // R10: blitter priority clear, CPU share
    wr(16'h0400, "R10");
    for (int i = 0; i < 32; i++) step("R10");
    req_cop = 1;
    for (int i = 0; i < 8; i++) step("R10");

    // R2: mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      {req_fix, req_bpl, req_cop, req_blt, req_cpu} = 8'($urandom);
      if (i % 16 == 0) begin
        hires = 1'($urandom);
        bpl_depth = 3'($urandom);
      end
      if ($urandom % 8 == 0) begin
        ctl_we = 1'b1;
        ctl_wdata = 16'($urandom);
        if ($urandom % 2 == 0) ctl_wdata = ctl_wdata | 16'h8200;
      end
      step("R2");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule